// File: doc/BRIEF.md
# CPU Status Flag Register

This block keeps the processor's condition state. The four arithmetic result flags are overflow, carry, zero and negative. The two machine-state flags are interrupt enable and supervisor mode. All six flags are stored on the falling edge of the main clock, which is the second half of each microcode cycle. The four arithmetic flags always load together as one group. A select input chooses where they load from: the ALU's flag outputs after an arithmetic operation, or the low nibble of the Z bus when a saved copy is read back from memory. Each machine-state flag has its own load strobe and takes its own Z-bus line. Microcode sets or clears a machine-state flag by making the ALU drive all zeros or all ones onto the Z bus while that flag's strobe is high.

The stored word goes to the microcode sequencer at all times, with no gating. The carry bit also goes to the ALU as a separate output. When the active-low read enable is low, the word is driven onto the 8-bit left bus, padded with zeros at the top, so it can be written to memory. At all other times that bus is released to high impedance. All pins are plain level-sensitive control and data lines. There is no handshake, so each load takes effect at the next falling edge with nothing to stall it.

Top module: `status_flag_reg`

## Requirements
- R1: When `rst_n` is low at a falling edge of `clk`, all six flags become 0. After reset, `seq_flags` reads 6'b000000, which means interrupts are disabled and the CPU is not in supervisor mode.
- R2: When `ld_alu` is high and `src_sel_z` is low at a falling edge, flags[3:0] load from `alu_flags_in`. The bit order is bit 0 overflow, bit 1 carry, bit 2 zero, bit 3 negative.
- R3: When `ld_alu` is high and `src_sel_z` is high at a falling edge, flags[3:0] load from `z_bus[3:0]`, with the same bit order as R2.
- R4: When `ld_ie` is high at a falling edge, flag bit 4 (interrupt enable) loads from `z_bus[4]`. No other bit changes unless its own strobe is high.
- R5: When `ld_sup` is high at a falling edge, flag bit 5 (supervisor mode) loads from `z_bus[5]`. No other bit changes unless its own strobe is high.
- R6: A flag group whose strobe is low keeps its value, whatever happens on `alu_flags_in`, `z_bus` and `src_sel_z`.
- R7: `seq_flags` always shows the stored six flags, and `alu_carry` always equals stored bit 1. Neither output depends on `rd_n`.
- R8: While `rd_n` is low, `left_bus` equals {2'b00, flags}. While `rd_n` is high, all eight lines of `left_bus` are high impedance.
- R9: Raising `ld_alu` (with `src_sel_z` high), `ld_ie` and `ld_sup` together restores all six flags from `z_bus[5:0]` in one cycle.
- R10: Reset has priority over every load strobe at the same falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock; flags store on its falling edge |
| rst_n | input | 1 | Synchronous active-low clear |
| alu_flags_in | input | 4 | Flag outputs of the ALU: {N, Z, C, V} |
| z_bus | input | 6 | Low six lines of the ALU result bus |
| src_sel_z | input | 1 | Source select for the arithmetic group: 0 = ALU flags, 1 = Z bus |
| ld_alu | input | 1 | Load strobe for the arithmetic flag group |
| ld_ie | input | 1 | Load strobe for interrupt enable |
| ld_sup | input | 1 | Load strobe for supervisor mode |
| rd_n | input | 1 | Active-low enable for driving the left bus |
| seq_flags | output | 6 | Stored flags, always presented to the sequencer |
| alu_carry | output | 1 | Stored carry, fed back to the ALU |
| left_bus | output | 8 | Flags padded to a byte, or high impedance |

## Verification
The bench attacks the source select by loading values that differ between `alu_flags_in` and `z_bus[3:0]`. A design that inverts the select, or ignores it, stores the wrong nibble. It raises each machine-state strobe on its own while the Z bus carries values that would disturb the other flags. A design whose strobes are crossed or shared changes a bit that should have held. It pulses reset together with all strobes and opposite Z data, which exposes a design where a load beats reset. It checks the left bus in both enable states, so a design that drives the bus while disabled, fills bits 7:6 with anything but zero, or orders the bits wrongly produces a mismatch.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int ALU_FLAG_W   = 4;
  localparam int STATE_FLAG_W = 2;
  localparam int FLAG_W       = ALU_FLAG_W + STATE_FLAG_W;
  localparam int LBUS_W       = 8;
  // position of the carry bit inside the arithmetic group
  localparam int CARRY_BIT    = 1;
endpackage

// File: rtl/sfr_alu_group.sv
module sfr_alu_group #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         use_z,
  input  logic [W-1:0] from_alu,
  input  logic [W-1:0] from_z,
  output logic [W-1:0] q
);
  logic [W-1:0] src;

  // two-source mux: arithmetic result or memory restore path
  always_comb begin
    src = use_z ? from_z : from_alu;
  end

  always_ff @(negedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= src;
  end
endmodule

// File: rtl/sfr_state_bit.sv
module sfr_state_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic d,
  output logic q
);
  always_ff @(negedge clk) begin
    if (!rst_n)    q <= 1'b0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/sfr_bus_drive.sv
module sfr_bus_drive #(
  parameter int DW = 6,
  parameter int BW = 8
) (
  input  logic          drive_n,
  input  logic [DW-1:0] data,
  output logic [BW-1:0] bus
);
  localparam int PAD_W = BW - DW;
  logic [BW-1:0] word;

  always_comb begin
    word = {{PAD_W{1'b0}}, data};
  end

  assign bus = drive_n ? {BW{1'bz}} : word;
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
  import sfr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ALU_FLAG_W-1:0] alu_flags_in,
  input  logic [FLAG_W-1:0]     z_bus,
  input  logic                  src_sel_z,
  input  logic                  ld_alu,
  input  logic                  ld_ie,
  input  logic                  ld_sup,
  input  logic                  rd_n,
  output logic [FLAG_W-1:0]     seq_flags,
  output logic                  alu_carry,
  output logic [LBUS_W-1:0]     left_bus
);
  logic [ALU_FLAG_W-1:0]   arith_q;
  logic [STATE_FLAG_W-1:0] state_q;
  logic [STATE_FLAG_W-1:0] state_ld;

  // strobe order follows the bit order: interrupt enable, then supervisor
  assign state_ld = {ld_sup, ld_ie};

  sfr_alu_group #(.W(ALU_FLAG_W)) u_arith (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld_alu),
    .use_z    (src_sel_z),
    .from_alu (alu_flags_in),
    .from_z   (z_bus[ALU_FLAG_W-1:0]),
    .q        (arith_q)
  );

  for (genvar i = 0; i < STATE_FLAG_W; i++) begin : g_state
    sfr_state_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (state_ld[i]),
      .d     (z_bus[ALU_FLAG_W+i]),
      .q     (state_q[i])
    );
  end

  assign seq_flags = {state_q, arith_q};
  assign alu_carry = arith_q[CARRY_BIT];

  sfr_bus_drive #(.DW(FLAG_W), .BW(LBUS_W)) u_drive (
    .drive_n (rd_n),
    .data    (seq_flags),
    .bus     (left_bus)
  );
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] alu_flags_in,
  input logic [5:0] z_bus,
  input logic       src_sel_z,
  input logic       ld_alu,
  input logic       ld_ie,
  input logic       ld_sup,
  input logic       rd_n,
  input logic [5:0] seq_flags,
  input logic [7:0] left_bus
);
  // R1
  reset_clears_chk: assert property (@(negedge clk)
    !rst_n |=> seq_flags == 6'b0);

  // R2
  alu_src_load_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (ld_alu && !src_sel_z) |=> seq_flags[3:0] == $past(alu_flags_in));

  // R3
  z_src_load_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (ld_alu && src_sel_z) |=> seq_flags[3:0] == $past(z_bus[3:0]));

  // R4
  ie_load_chk: assert property (@(negedge clk) disable iff (!rst_n)
    ld_ie |=> seq_flags[4] == $past(z_bus[4]));

  // R5
  sup_load_chk: assert property (@(negedge clk) disable iff (!rst_n)
    ld_sup |=> seq_flags[5] == $past(z_bus[5]));

  // R6
  arith_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
    !ld_alu |=> $stable(seq_flags[3:0]));

  // R6
  state_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (!ld_ie && !ld_sup) |=> $stable(seq_flags[5:4]));

  // R8
  bus_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> left_bus == {2'b00, seq_flags});
endmodule

bind status_flag_reg sfr_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .alu_flags_in (alu_flags_in),
  .z_bus        (z_bus),
  .src_sel_z    (src_sel_z),
  .ld_alu       (ld_alu),
  .ld_ie        (ld_ie),
  .ld_sup       (ld_sup),
  .rd_n         (rd_n),
  .seq_flags    (seq_flags),
  .left_bus     (left_bus)
);

// File: tb/sim_status_flag_reg.sv
module sim_status_flag_reg;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  typedef struct {
    string      req;
    logic [5:0] flags;
    logic [7:0] bus;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] alu_flags_in = '0;
  logic [5:0] z_bus = '0;
  logic       src_sel_z = 1'b0;
  logic       ld_alu = 1'b0;
  logic       ld_ie = 1'b0;
  logic       ld_sup = 1'b0;
  logic       rd_n = 1'b1;
  logic [5:0] seq_flags;
  logic       alu_carry;
  logic [7:0] left_bus;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  logic [5:0] model = '0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  status_flag_reg u0 (
    .clk(clk), .rst_n(rst_n), .alu_flags_in(alu_flags_in), .z_bus(z_bus),
    .src_sel_z(src_sel_z), .ld_alu(ld_alu), .ld_ie(ld_ie), .ld_sup(ld_sup),
    .rd_n(rd_n), .seq_flags(seq_flags), .alu_carry(alu_carry), .left_bus(left_bus)
  );

  // driver: one call is one cycle; inputs change after the rising edge,
  // the design stores at the following falling edge
  task automatic step(input string req, input logic rst, input logic [3:0] af,
                      input logic [5:0] z, input logic sel, input logic la,
                      input logic lie, input logic lsup, input logic rd);
    exp_t e;
    @(posedge clk);
    #1;
    rst_n = rst; alu_flags_in = af; z_bus = z; src_sel_z = sel;
    ld_alu = la; ld_ie = lie; ld_sup = lsup; rd_n = rd;
    if (!rst) model = '0;                       // R1, R10
    else begin
      if (la) model[3:0] = sel ? z[3:0] : af;   // R2, R3
      if (lie) model[4] = z[4];                 // R4
      if (lsup) model[5] = z[5];                // R5
    end
    e.req = req;
    e.flags = model;
    e.bus = rd ? 8'bzzzzzzzz : {2'b00, model};  // R8
    sb.push_back(e);
  endtask

  // monitor: compare a quarter period after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (seq_flags !== e.flags) begin
          errors++;
          $display("FAIL %s seq_flags actual=%b expected=%b", e.req, seq_flags, e.flags);
        end
        checks++;
        if (alu_carry !== e.flags[1]) begin
          errors++;
          $display("FAIL R7 alu_carry (%s) actual=%b expected=%b", e.req, alu_carry, e.flags[1]);
        end
        checks++;
        if (left_bus !== e.bus) begin
          errors++;
          $display("FAIL R8 left_bus (%s) actual=%b expected=%b", e.req, left_bus, e.bus);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < WATCHDOG && !done; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state, bus released
    step("R1", 0, 4'hF, 6'h3F, 1, 0, 0, 0, 1);
    step("R1", 0, 4'h0, 6'h00, 0, 0, 0, 0, 0);
    // R2: ALU source with Z bus carrying a different nibble
    step("R2", 1, 4'b1010, 6'b000101, 0, 1, 0, 0, 0);
    step("R2", 1, 4'b0110, 6'b001001, 0, 1, 0, 0, 1);
    // R3: Z source, ALU inputs differ
    step("R3", 1, 4'b0000, 6'b001101, 1, 1, 0, 0, 0);
    step("R3", 1, 4'b1111, 6'b000010, 1, 1, 0, 0, 0);
    // R4: set then clear interrupt enable with all-ones / all-zeros Z
    step("R4", 1, 4'b1111, 6'b111111, 1, 0, 1, 0, 0);
    step("R4", 1, 4'b0000, 6'b000000, 0, 0, 1, 0, 0);
    // R5: supervisor only, other Z bits toggled
    step("R5", 1, 4'b1111, 6'b111111, 1, 0, 0, 1, 0);
    step("R5", 1, 4'b0101, 6'b011111, 0, 0, 0, 1, 1);
    step("R5", 1, 4'b0000, 6'b100000, 1, 0, 0, 1, 0);
    // R6: no strobes, inputs wiggle
    step("R6", 1, 4'b1001, 6'b010110, 1, 0, 0, 0, 0);
    step("R6", 1, 4'b0110, 6'b101001, 0, 0, 0, 0, 1);
    // R9: full restore
    step("R9", 1, 4'b1111, 6'b010110, 1, 1, 1, 1, 0);
    step("R9", 1, 4'b0000, 6'b101001, 1, 1, 1, 1, 0);
    // R7: carry follows bit 1 with bus released
    step("R7", 1, 4'b0010, 6'b000000, 0, 1, 0, 0, 1);
    step("R7", 1, 4'b1101, 6'b000000, 0, 1, 0, 0, 1);
    // R10: reset beats every strobe
    step("R10", 1, 4'b1111, 6'b111111, 1, 1, 1, 1, 0);
    step("R10", 0, 4'b1111, 6'b111111, 1, 1, 1, 1, 0);
    step("R10", 1, 4'b0000, 6'b000000, 0, 0, 0, 0, 0);
    step("R8", 1, 4'b0000, 6'b000000, 0, 0, 0, 0, 1);
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule